// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block generates the read/write strobe for a single programmed-I/O data transfer on an IDE-style drive bus. The shape of the strobe comes from an 8-bit timing byte. The byte holds two fields: a recovery field in bits [7:4] and an active field in the low bits. Both fields are kept as "offset minus clock count", where a clock is one local-bus clock. The block holds two such bytes. A host loads each byte through a plain write port.

When a transfer is requested, the block first picks one timing byte with a select input and decodes it. It then drives the strobe high for the active count and low for the recovery count, and raises a one-clock done pulse at the end. Two decode variants are supported, and the `dual_mode` input chooses between them. In the single-channel variant, the `slow_bus` speed-grade input selects one of two count ranges.

A decoded count that falls outside its legal range is clamped to the nearest bound before counting starts. A request that arrives during a cycle is not accepted; `busy` tells the host to keep holding it. Writes that arrive while a cycle is running are dropped.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, `strobe`, `busy` and `done` are low and both timing registers hold 0x00, which is the slowest encoding. In dual decode that gives 17 active and 15 recovery clocks. In single decode with `slow_bus`=1 it gives 9 and 15. In single decode with `slow_bus`=0 it gives 8 and 18.
- R2: With `dual_mode`=1, let L = byte[3:0] and H = byte[7:4]. The active count is 17-L and the recovery count is 15-H.
- R3: With `dual_mode`=1, a recovery value that decodes below 2 (H of 14 or 15) is clamped to 2 clocks.
- R4: With `dual_mode`=0 and `slow_bus`=1, the active count is 9-byte[2:0] and the recovery count is 15-byte[7:4]. Bit 3 has no effect.
- R5: With `dual_mode`=0 and `slow_bus`=0, the active count is 8-byte[2:0] and the recovery count is 18-byte[7:4]. Bit 3 has no effect.
- R6: The block accepts a request at the rising edge when `req` is high and `busy` is low. From the cycle after that edge, `strobe` is high for exactly the active count. It is then low with `busy` high for the recovery count. After that, `done` is high for exactly one cycle with `busy` low. A recovery count of 0 puts `done` in the cycle right after the strobe falls.
- R7: A request while `busy` is high starts nothing. A request held high through the end of a cycle is accepted at the edge that ends the `done` cycle.
- R8: The register used for a cycle is chosen by `req_sel` at acceptance: index 0 or 1. A write goes to the register chosen by `wr_sel`.
- R9: A write presented while `busy` is high leaves both timing registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 1 | Index of the register to write |
| wr_data | input | 8 | Timing byte to write |
| dual_mode | input | 1 | 1 selects dual-channel decode, 0 selects single-channel decode |
| slow_bus | input | 1 | Speed grade: 1 means bus at or below 33 MHz, 0 means above |
| req | input | 1 | Transfer request |
| req_sel | input | 1 | Index of the timing register for the requested cycle |
| strobe | output | 1 | Drive-bus read/write strobe, high while active |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
Each output is due at a known cycle after the request is presented:
- `strobe` is first high in the cycle after the accepting edge.
- It stays high for the active count, then goes low for the recovery count.
- `done` follows in the next cycle.
- A register write takes effect at the edge that samples `wr_en`.

The bench drives inputs and samples outputs on falling edges. It presents a request, releases it after one edge, and then counts strobe-high cycles and strobe-low cycles until `done`. It compares both counts with widths computed from the decode formulas, for every byte value under all three decode settings. For the held-request and busy-write cases, it checks the outputs in the exact cycle right after `done`.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int TIM_W     = 8;
    localparam int NUM_TREGS = 2;
    localparam int SEL_W     = (NUM_TREGS > 1) ? $clog2(NUM_TREGS) : 1;
    localparam int CNT_W     = 5;

    // decode offsets and legal ranges
    localparam int DU_ACT_OFS = 17, DU_ACT_MIN = 2, DU_ACT_MAX = 17;
    localparam int DU_REC_OFS = 15, DU_REC_MIN = 2, DU_REC_MAX = 15;
    localparam int SL_ACT_OFS = 9,  SL_ACT_MIN = 2, SL_ACT_MAX = 9;
    localparam int SL_REC_OFS = 15, SL_REC_MIN = 0, SL_REC_MAX = 15;
    localparam int FA_ACT_OFS = 8,  FA_ACT_MIN = 1, FA_ACT_MAX = 8;
    localparam int FA_REC_OFS = 18, FA_REC_MIN = 3, FA_REC_MAX = 18;

    localparam logic [TIM_W-1:0] TIM_RESET = '0;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_REC  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        cnt_t   cnt;
        cnt_t   rec;
        logic   strobe;
        logic   done;
    } seq_t;

    function automatic cnt_t clamp_count(int offset, int field, int lo, int hi);
        int v;
        v = offset - field;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return cnt_t'(v);
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_strobe_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [TIM_W-1:0]             wr_data,
    input  logic                         busy,
    output logic [NUM_TREGS*TIM_W-1:0]   regs_flat
);

    logic wr_ok;
    assign wr_ok = wr_en && !busy;

    for (genvar g = 0; g < NUM_TREGS; g++) begin : g_treg
        logic [TIM_W-1:0] tim_d, tim_q;

        always_comb begin
            tim_d = tim_q;
            if (wr_ok && (wr_sel == SEL_W'(g))) begin
                tim_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_q <= TIM_RESET;
            end else begin
                tim_q <= tim_d;
            end
        end

        assign regs_flat[g*TIM_W +: TIM_W] = tim_q;
    end

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
    import pio_strobe_pkg::*;
(
    input  logic [TIM_W-1:0] tim_byte,
    input  logic             dual_mode,
    input  logic             slow_bus,
    output cnt_t             act_cnt,
    output cnt_t             rec_cnt
);

    int lo4, lo3, hi4;

    always_comb begin
        lo4 = int'(tim_byte[3:0]);
        lo3 = int'(tim_byte[2:0]);
        hi4 = int'(tim_byte[7:4]);
        if (dual_mode) begin
            act_cnt = clamp_count(DU_ACT_OFS, lo4, DU_ACT_MIN, DU_ACT_MAX);
            rec_cnt = clamp_count(DU_REC_OFS, hi4, DU_REC_MIN, DU_REC_MAX);
        end else if (slow_bus) begin
            act_cnt = clamp_count(SL_ACT_OFS, lo3, SL_ACT_MIN, SL_ACT_MAX);
            rec_cnt = clamp_count(SL_REC_OFS, hi4, SL_REC_MIN, SL_REC_MAX);
        end else begin
            act_cnt = clamp_count(FA_ACT_OFS, lo3, FA_ACT_MIN, FA_ACT_MAX);
            rec_cnt = clamp_count(FA_REC_OFS, hi4, FA_REC_MIN, FA_REC_MAX);
        end
    end

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  cnt_t act_cnt,
    input  cnt_t rec_cnt,
    output logic strobe,
    output logic busy,
    output logic done
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req) begin
                    seq_d.phase  = PH_ACT;
                    seq_d.cnt    = cnt_t'(act_cnt - cnt_t'(1));
                    seq_d.rec    = rec_cnt;
                    seq_d.strobe = 1'b1;
                end
            end
            PH_ACT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.strobe = 1'b0;
                    if (seq_q.rec == '0) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.phase = PH_REC;
                        seq_d.cnt   = cnt_t'(seq_q.rec - cnt_t'(1));
                    end
                end else begin
                    seq_d.cnt = cnt_t'(seq_q.cnt - cnt_t'(1));
                end
            end
            PH_REC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.cnt = cnt_t'(seq_q.cnt - cnt_t'(1));
                end
            end
            default: begin
                seq_d.phase  = PH_IDLE;
                seq_d.strobe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0, rec: '0, strobe: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign strobe = seq_q.strobe;
    assign busy   = (seq_q.phase != PH_IDLE);
    assign done   = seq_q.done;

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [TIM_W-1:0] wr_data,
    input  logic             dual_mode,
    input  logic             slow_bus,
    input  logic             req,
    input  logic [SEL_W-1:0] req_sel,
    output logic             strobe,
    output logic             busy,
    output logic             done
);

    logic [NUM_TREGS*TIM_W-1:0] tim_flat;
    logic [TIM_W-1:0]           tim_cur;
    cnt_t                       act_cnt;
    cnt_t                       rec_cnt;

    pio_timing_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .busy      (busy),
        .regs_flat (tim_flat)
    );

    assign tim_cur = tim_flat[int'(req_sel)*TIM_W +: TIM_W];

    pio_timing_decode u_dec (
        .tim_byte  (tim_cur),
        .dual_mode (dual_mode),
        .slow_bus  (slow_bus),
        .act_cnt   (act_cnt),
        .rec_cnt   (rec_cnt)
    );

    pio_strobe_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .act_cnt (act_cnt),
        .rec_cnt (rec_cnt),
        .strobe  (strobe),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk
    import pio_strobe_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req,
    input logic                       strobe,
    input logic                       busy,
    input logic                       done,
    input logic [NUM_TREGS*TIM_W-1:0] tim_flat
);

    // R6
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    // R6
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (strobe && busy));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !strobe));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tim_flat));

endmodule

bind pio_strobe_gen pio_strobe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .tim_flat (tim_flat)
);

// File: tb/sim_pio_strobe_gen.sv
`timescale 1ns/1ps
module sim_pio_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       dual_mode = 1'b1;
    logic       slow_bus = 1'b1;
    logic       req = 1'b0;
    logic [0:0] req_sel = '0;
    logic       strobe, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pio_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dual_mode(dual_mode), .slow_bus(slow_bus),
        .req(req), .req_sel(req_sel), .strobe(strobe), .busy(busy), .done(done)
    );

    function automatic int exp_act(bit d, bit s, logic [7:0] b);
        if (d) return 17 - int'(b[3:0]);
        if (s) return 9 - int'(b[2:0]);
        return 8 - int'(b[2:0]);
    endfunction

    function automatic int exp_rec(bit d, bit s, logic [7:0] b);
        int v;
        if (d) begin
            v = 15 - int'(b[7:4]);
            return (v < 2) ? 2 : v;
        end
        if (s) return 15 - int'(b[7:4]);
        return 18 - int'(b[7:4]);
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic wr(input bit sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    endtask

    task automatic xfer(input bit sel, input int ea, input int er, input string tag);
        int hi, lo;
        @(negedge clk);
        req = 1'b1; req_sel = sel;
        @(negedge clk);
        req = 1'b0;
        hi = 0;
        while (strobe && hi < 40) begin hi++; @(negedge clk); end
        lo = 0;
        while (!strobe && !done && lo < 40) begin lo++; @(negedge clk); end
        check(hi == ea, {tag, " active width"}, hi, ea);
        check(lo == er, {tag, " recovery width"}, lo, er);
        check(done && !busy, "R6 done pulse after recovery", int'(done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] b;
        string tag;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!strobe && !busy && !done, "R1 outputs after reset", int'({strobe, busy, done}), 0);
        dual_mode = 1; xfer(0, 17, 15, "R1 dual reg0");
        dual_mode = 0; slow_bus = 1; xfer(1, 9, 15, "R1 slow reg1");
        slow_bus = 0; xfer(0, 8, 18, "R1 fast reg0");

        // R2 R3 R4 R5 exhaustive encodings, random register choice
        for (int m = 0; m < 3; m++) begin
            dual_mode = (m == 0);
            slow_bus  = (m == 1);
            for (int v = 0; v < 256; v++) begin
                bit s;
                b = 8'(v);
                s = 1'($urandom % 2);
                if (m == 0) tag = (b[7:4] >= 4'd14) ? "R3 dual clamp" : "R2 dual";
                else if (m == 1) tag = "R4 single slow";
                else tag = "R5 single fast";
                wr(s, b);
                xfer(s, exp_act(dual_mode, slow_bus, b), exp_rec(dual_mode, slow_bus, b), tag);
            end
        end

        // R8 register select
        dual_mode = 1;
        wr(0, 8'h11);
        wr(1, 8'hEE);
        xfer(1, 3, 2, "R8 select reg1");
        xfer(0, 16, 14, "R8 select reg0");

        // R9 write while busy ignored
        wr(0, 8'h00);
        @(negedge clk); req = 1'b1; req_sel = 0;
        @(negedge clk); req = 1'b0; wr_en = 1'b1; wr_sel = 0; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        wait_done();
        xfer(0, 17, 15, "R9 busy write ignored");

        // R7 request during busy ignored
        wr(0, 8'h0E);
        @(negedge clk); req = 1'b1; req_sel = 0;
        @(negedge clk); req = 1'b0;
        repeat (6) @(negedge clk);
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        wait_done();
        @(negedge clk);
        check(!strobe && !busy, "R7 busy request ignored", int'(strobe), 0);

        // R7 held request restarts right after done
        @(negedge clk); req = 1'b1; req_sel = 0;
        @(negedge clk);
        wait_done();
        check(done, "R7 held request done seen", int'(done), 1);
        @(negedge clk);
        check(strobe && busy, "R7 held request restart", int'(strobe), 1);
        req = 1'b0;
        wait_done();

        // R6 zero recovery back to back
        dual_mode = 0; slow_bus = 1;
        wr(1, 8'hF8);
        xfer(1, 9, 0, "R6 zero recovery");
        xfer(1, 9, 0, "R6 zero recovery again");

        summary();
        $finish;
    end

endmodule